// File: doc/BRIEF.md
# Maintenance Hop-Count Forwarder

This block is the header-steering stage of a switch that owns no device identifier. Each cycle it may take one packet header: a maintenance flag, a flag marking a response launched by this switch's own register-access port, a destination identifier, an 8-bit hop count and an opaque tag. One cycle later it reports exactly one outcome for that header. The header is either handed to the local register-access port, sent to a set of egress ports, or discarded with an error count.

For maintenance traffic the choice between local and forward depends only on the hop count as received. A count of zero means the access targets this switch. Any other count is reduced by one and the packet is routed on. Ordinary traffic ignores the hop count and is routed by destination identifier alone. Responses launched from the local port leave with the maximum hop count, so no switch on the way can take them as its own. The routing table holds one entry per destination identifier and is loaded through a configuration write port. Each entry names either one egress port or a set of egress ports.

Top module: `hopfwd_top`

## Requirements
- R1: A maintenance header (`hdr_maint`=1, `hdr_local`=0) with hop count 0 raises `loc_valid` on the next cycle, with no forward and no discard. This happens whatever the routing entry holds and leaves `err_count` unchanged.
- R2: A maintenance header (`hdr_local`=0) with a nonzero hop count h that is forwarded leaves with `fwd_hop` = h-1. For example, 1 becomes 0 and 0xFF becomes 0xFE. `fwd_maint` is 1.
- R3: A forwarded header takes its egress set from the entry indexed by `hdr_dest`. For a single-port entry, `fwd_mask` has only bit p set, where p is the port index in the low log2(PORTS) bits of the entry.
- R4: A header with `hdr_local`=1 is a locally launched maintenance response. It is never delivered locally, is routed by `hdr_dest`, and leaves with `fwd_hop`=0xFF whatever `hdr_hop` holds.
- R5: A multi-port entry drives `fwd_mask` with the stored port mask, so several bits may be set.
- R6: A non-maintenance header (`hdr_maint`=0, `hdr_local`=0) is routed by `hdr_dest` and keeps its hop field unchanged, even when that field is 0. It is never delivered locally.
- R7: `cfg_data` is {programmed (bit PORTS+1), multi-port (bit PORTS), payload (bits PORTS-1:0)} and is written to entry `cfg_id` when `cfg_we`=1. The payload is a port mask for a multi-port entry and a port index for a single-port entry. A write in the same cycle as a header does not affect that header; the next header sees it.
- R8: If the entry is not programmed, or is a multi-port entry with an empty mask, the header is discarded: `drop_valid` rises and `err_count` increments in the same cycle.
- R9: `err_count` saturates at its maximum (255 by default) and does not wrap.
- R10: After reset all outputs are low, `err_count` is 0, and every routing entry is unprogrammed.
- R11: Each outcome appears exactly one cycle after its header, with `out_tag` equal to that header's tag. Cycles without a header produce no outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | Header present this cycle |
| hdr_maint | input | 1 | Header is a maintenance packet |
| hdr_local | input | 1 | Header is a response launched by the local register-access port |
| hdr_dest | input | ID_W | Destination identifier |
| hdr_hop | input | 8 | Hop count field as received |
| hdr_tag | input | TAG_W | Opaque tag carried to the outcome |
| cfg_we | input | 1 | Routing entry write strobe |
| cfg_id | input | ID_W | Routing entry index |
| cfg_data | input | PORTS+2 | Routing entry contents |
| loc_valid | output | 1 | Header delivered to the local register-access port |
| fwd_valid | output | 1 | Header forwarded |
| fwd_mask | output | PORTS | Egress port set (zero when not forwarding) |
| fwd_hop | output | 8 | Outgoing hop count |
| fwd_maint | output | 1 | Forwarded header is maintenance traffic |
| drop_valid | output | 1 | Header discarded |
| out_tag | output | TAG_W | Tag of the header that produced the outcome |
| err_count | output | ERR_W | Saturating count of discarded headers |

## Verification
The bench aims at the hop-count boundaries. A zero count must be consumed even when the destination has no route; a design that looked up the route first would discard it. A count of 1 must leave as 0, and 0xFF must leave as 0xFE; an off-by-one or a wrap would show there. Local responses sent with a hop field of 0 must still leave with 0xFF, and non-maintenance headers with a zero hop field must not be taken locally. A design that wrote the table ahead of a same-cycle header would route that header by the new entry. A wrapping error counter would read 0 after the 256th discard.

// File: rtl/hopfwd_pkg.sv
package hopfwd_pkg;
   localparam int HOP_W = 8;
   localparam logic [HOP_W-1:0] HOP_MAX = '1;

   typedef enum logic [1:0] {
      ACT_NONE  = 2'd0,
      ACT_LOCAL = 2'd1,
      ACT_FWD   = 2'd2,
      ACT_DROP  = 2'd3
   } hop_act_e;
endpackage

// File: rtl/hopfwd_route_table.sv
module hopfwd_route_table #(
   parameter int ID_W  = 4,
   parameter int PORTS = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ID_W-1:0]    wr_id,
   input  logic [PORTS+1:0]   wr_data,
   input  logic [ID_W-1:0]    rd_id,
   output logic               rd_hit,
   output logic [PORTS-1:0]   rd_mask
);
   localparam int ENTRIES = 1 << ID_W;
   localparam int DW      = PORTS + 2;
   localparam int PIDX_W  = $clog2(PORTS);

   if (PORTS < 2 || (PORTS & (PORTS - 1)) != 0) begin : g_bad_ports
      $error("hopfwd_route_table: PORTS must be a power of two, at least 2");
   end
   if (ID_W < 1 || ID_W > 10) begin : g_bad_idw
      $error("hopfwd_route_table: ID_W out of range");
   end

   logic [DW-1:0] ent_q [ENTRIES];

   for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      always_ff @(posedge clk) begin
         if (!rst_n)
            ent_q[g] <= '0;
         else if (wr_en && wr_id == ID_W'(g))
            ent_q[g] <= wr_data;
      end
   end

   logic [DW-1:0]     sel;
   logic [PIDX_W-1:0] uni_idx;
   logic [PORTS-1:0]  uni_mask;

   always_comb begin
      sel      = ent_q[rd_id];
      uni_idx  = sel[PIDX_W-1:0];
      uni_mask = PORTS'(1) << uni_idx;
      rd_mask  = sel[PORTS] ? sel[PORTS-1:0] : uni_mask;
      rd_hit   = sel[PORTS+1] && (rd_mask != '0);
   end
endmodule

// File: rtl/hopfwd_decide.sv
module hopfwd_decide
   import hopfwd_pkg::*;
(
   input  logic             maint,
   input  logic             local_rsp,
   input  logic [HOP_W-1:0] hop_in,
   input  logic             route_hit,
   output hop_act_e         act,
   output logic [HOP_W-1:0] hop_out
);
   always_comb begin
      hop_out = hop_in;
      if (local_rsp) begin
         act     = route_hit ? ACT_FWD : ACT_DROP;
         hop_out = HOP_MAX;
      end else if (maint && hop_in == '0) begin
         act = ACT_LOCAL;
      end else begin
         act = route_hit ? ACT_FWD : ACT_DROP;
         if (maint)
            hop_out = hop_in - HOP_W'(1);
      end
   end
endmodule

// File: rtl/hopfwd_err_ctr.sv
module hopfwd_err_ctr #(
   parameter int ERR_W   = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   output logic [ERR_W-1:0] cnt
);
   localparam logic [ERR_W-1:0] CNT_MAX = '1;

   if (ERR_W < 1) begin : g_bad_w
      $error("hopfwd_err_ctr: ERR_W must be positive");
   end

   logic [ERR_W-1:0] cnt_q;

   if (SATURATE) begin : g_sat
      always_ff @(posedge clk) begin
         if (!rst_n)
            cnt_q <= '0;
         else if (inc && cnt_q != CNT_MAX)
            cnt_q <= cnt_q + ERR_W'(1);
      end

      assert_err_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
         cnt_q == CNT_MAX |=> cnt_q == CNT_MAX);
   end else begin : g_wrap
      always_ff @(posedge clk) begin
         if (!rst_n)
            cnt_q <= '0;
         else if (inc)
            cnt_q <= cnt_q + ERR_W'(1);
      end
   end

   assert_err_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !inc |=> $stable(cnt_q));

   assign cnt = cnt_q;
endmodule

// File: rtl/hopfwd_top.sv
module hopfwd_top
   import hopfwd_pkg::*;
#(
   parameter int ID_W     = 4,
   parameter int PORTS    = 4,
   parameter int TAG_W    = 8,
   parameter int ERR_W    = 8,
   parameter bit ERR_SAT  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hdr_valid,
   input  logic             hdr_maint,
   input  logic             hdr_local,
   input  logic [ID_W-1:0]  hdr_dest,
   input  logic [7:0]       hdr_hop,
   input  logic [TAG_W-1:0] hdr_tag,
   input  logic             cfg_we,
   input  logic [ID_W-1:0]  cfg_id,
   input  logic [PORTS+1:0] cfg_data,
   output logic             loc_valid,
   output logic             fwd_valid,
   output logic [PORTS-1:0] fwd_mask,
   output logic [7:0]       fwd_hop,
   output logic             fwd_maint,
   output logic             drop_valid,
   output logic [TAG_W-1:0] out_tag,
   output logic [ERR_W-1:0] err_count
);
   if (TAG_W < 1) begin : g_bad_tag
      $error("hopfwd_top: TAG_W must be positive");
   end

   logic             rt_hit;
   logic [PORTS-1:0] rt_mask;
   hop_act_e         act;
   logic [HOP_W-1:0] nxt_hop;
   logic             take_hdr;

   hopfwd_route_table #(.ID_W(ID_W), .PORTS(PORTS)) u_table (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we),
      .wr_id   (cfg_id),
      .wr_data (cfg_data),
      .rd_id   (hdr_dest),
      .rd_hit  (rt_hit),
      .rd_mask (rt_mask)
   );

   hopfwd_decide u_decide (
      .maint     (hdr_maint),
      .local_rsp (hdr_local),
      .hop_in    (hdr_hop),
      .route_hit (rt_hit),
      .act       (act),
      .hop_out   (nxt_hop)
   );

   assign take_hdr = hdr_valid && act != ACT_NONE;

   hopfwd_err_ctr #(.ERR_W(ERR_W), .SATURATE(ERR_SAT)) u_err (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (take_hdr && act == ACT_DROP),
      .cnt   (err_count)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         loc_valid  <= 1'b0;
         fwd_valid  <= 1'b0;
         drop_valid <= 1'b0;
         fwd_mask   <= '0;
         fwd_hop    <= '0;
         fwd_maint  <= 1'b0;
         out_tag    <= '0;
      end else begin
         loc_valid  <= take_hdr && act == ACT_LOCAL;
         fwd_valid  <= take_hdr && act == ACT_FWD;
         drop_valid <= take_hdr && act == ACT_DROP;
         fwd_mask   <= (take_hdr && act == ACT_FWD) ? rt_mask : '0;
         fwd_hop    <= nxt_hop;
         fwd_maint  <= hdr_maint || hdr_local;
         if (hdr_valid)
            out_tag <= hdr_tag;
      end
   end

   // one outcome per header
   assert_one_outcome_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({loc_valid, fwd_valid, drop_valid}));

   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !hdr_valid |=> !(loc_valid || fwd_valid || drop_valid));

   assert_zero_local_R1: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_valid && hdr_maint && !hdr_local && hdr_hop == 8'd0 |=> loc_valid);

   assert_hop_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_valid && hdr_maint && !hdr_local && hdr_hop != 8'd0
      |=> loc_valid == 1'b0 && (!fwd_valid || fwd_hop == $past(hdr_hop) - 8'd1));

   assert_rsp_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_valid && hdr_local |=> !loc_valid && (!fwd_valid || fwd_hop == 8'hFF));

   assert_fwd_nonempty_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid |-> fwd_mask != '0);

   assert_plain_hop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_valid && !hdr_maint && !hdr_local
      |=> !loc_valid && (!fwd_valid || fwd_hop == $past(hdr_hop)));
endmodule

// File: tb/hopfwd_top_bench.sv
module hopfwd_top_bench;
   localparam int ID_W  = 4;
   localparam int PORTS = 4;
   localparam int TAG_W = 8;
   localparam int ERR_W = 8;
   localparam int NENT  = 1 << ID_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic             hdr_valid = 0, hdr_maint = 0, hdr_local = 0;
   logic [ID_W-1:0]  hdr_dest = '0;
   logic [7:0]       hdr_hop = '0;
   logic [TAG_W-1:0] hdr_tag = '0;
   logic             cfg_we = 0;
   logic [ID_W-1:0]  cfg_id = '0;
   logic [PORTS+1:0] cfg_data = '0;
   logic             loc_valid, fwd_valid, fwd_maint, drop_valid;
   logic [PORTS-1:0] fwd_mask;
   logic [7:0]       fwd_hop;
   logic [TAG_W-1:0] out_tag;
   logic [ERR_W-1:0] err_count;

   hopfwd_top u_hopfwd_top (
      .clk(clk), .rst_n(rst_n),
      .hdr_valid(hdr_valid), .hdr_maint(hdr_maint), .hdr_local(hdr_local),
      .hdr_dest(hdr_dest), .hdr_hop(hdr_hop), .hdr_tag(hdr_tag),
      .cfg_we(cfg_we), .cfg_id(cfg_id), .cfg_data(cfg_data),
      .loc_valid(loc_valid), .fwd_valid(fwd_valid), .fwd_mask(fwd_mask),
      .fwd_hop(fwd_hop), .fwd_maint(fwd_maint), .drop_valid(drop_valid),
      .out_tag(out_tag), .err_count(err_count)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;
   int model_tab [NENT];
   int exp_err = 0;
   int tag_ctr = 1;

   function automatic int model_mask(input int d);
      int e = model_tab[d];
      if (((e >> (PORTS + 1)) & 1) == 0) return 0;
      if (((e >> PORTS) & 1) == 1) return e & ((1 << PORTS) - 1);
      return 1 << (e & (PORTS - 1));
   endfunction

   task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
      end
   endtask

   // one cycle: drive at negedge, compare after the next posedge
   task automatic cyc(input bit v, input bit m, input bit l, input int dest, input int hop,
                      input bit we, input int wid, input int wdata, input string rq);
      int  e_loc = 0, e_fwd = 0, e_drop = 0, e_mask = 0, e_hop = 0, e_maint = 0, e_tag;
      int  mk;
      e_tag = tag_ctr & 8'hFF;
      if (v) begin
         mk = model_mask(dest);
         if (l) begin
            if (mk != 0) begin e_fwd = 1; e_mask = mk; e_hop = 255; e_maint = 1; end
            else e_drop = 1;
         end else if (m && hop == 0) begin
            e_loc = 1;
         end else if (mk != 0) begin
            e_fwd = 1; e_mask = mk; e_hop = m ? hop - 1 : hop; e_maint = m;
         end else e_drop = 1;
         if (e_drop && exp_err < 255) exp_err++;
      end
      if (we) model_tab[wid] = wdata;
      hdr_valid = v; hdr_maint = m; hdr_local = l;
      hdr_dest = ID_W'(dest); hdr_hop = 8'(hop); hdr_tag = 8'(e_tag);
      cfg_we = we; cfg_id = ID_W'(wid); cfg_data = (PORTS+2)'(wdata);
      @(posedge clk);
      @(negedge clk);
      tag_ctr++;
      chk(loc_valid == 1'(e_loc), rq, "loc_valid", int'(loc_valid), e_loc);
      chk(fwd_valid == 1'(e_fwd), rq, "fwd_valid", int'(fwd_valid), e_fwd);
      chk(drop_valid == 1'(e_drop), rq, "drop_valid", int'(drop_valid), e_drop);
      chk(int'(fwd_mask) == e_mask, rq, "fwd_mask", int'(fwd_mask), e_mask);
      if (e_fwd) begin
         chk(int'(fwd_hop) == e_hop, rq, "fwd_hop", int'(fwd_hop), e_hop);
         chk(fwd_maint == 1'(e_maint), rq, "fwd_maint", int'(fwd_maint), e_maint);
      end
      if (v) chk(int'(out_tag) == e_tag, rq, "out_tag", int'(out_tag), e_tag);
      chk(int'(err_count) == exp_err, rq, "err_count", int'(err_count), exp_err);
   endtask

   initial begin
      #200000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NENT; i++) model_tab[i] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R10 reset state
      chk(!loc_valid && !fwd_valid && !drop_valid, "R10", "outputs", 0, 0);
      chk(err_count == 0, "R10", "err_count", int'(err_count), 0);
      rst_n = 1'b1;
      // R10 unprogrammed entries discard, R8 counts
      cyc(1, 0, 0, 3, 7, 0, 0, 0, "R10");
      cyc(1, 1, 0, 0, 4, 0, 0, 0, "R10");
      // R7 programming: single-port/multi-port encodings
      cyc(0, 0, 0, 0, 0, 1, 1, 'h22, "R7");  // dest 1 -> port 2
      cyc(0, 0, 0, 0, 0, 1, 2, 'h3B, "R7");  // dest 2 -> ports 0,1,3
      cyc(0, 0, 0, 0, 0, 1, 5, 'h30, "R7");  // dest 5 multi-port, empty
      cyc(0, 0, 0, 0, 0, 1, 7, 'h23, "R11"); // dest 7 -> port 3
      // R1 zero hop consumed even without a route
      cyc(1, 1, 0, 9, 0, 0, 0, 0, "R1");
      cyc(1, 1, 0, 1, 0, 0, 0, 0, "R1");
      // R2 decrement boundaries, R3 single port, R5 multi-port
      cyc(1, 1, 0, 1, 1, 0, 0, 0, "R2");
      cyc(1, 1, 0, 2, 255, 0, 0, 0, "R5");
      cyc(1, 1, 0, 7, 9, 0, 0, 0, "R3");
      // R4 local responses leave with maximum hop
      cyc(1, 1, 1, 7, 0, 0, 0, 0, "R4");
      cyc(1, 0, 1, 2, 5, 0, 0, 0, "R4");
      cyc(1, 1, 1, 9, 0, 0, 0, 0, "R4");
      // R6 plain traffic with zero hop is routed unchanged
      cyc(1, 0, 0, 1, 0, 0, 0, 0, "R6");
      cyc(1, 0, 0, 2, 200, 0, 0, 0, "R6");
      // R8 empty multi-port mask discards
      cyc(1, 1, 0, 5, 3, 0, 0, 0, "R8");
      // R7 same-cycle write does not affect current header
      cyc(1, 1, 0, 4, 2, 1, 4, 'h21, "R7");
      cyc(1, 1, 0, 4, 2, 0, 0, 0, "R7");
      cyc(1, 0, 0, 1, 6, 1, 1, 'h3C, "R7");
      cyc(1, 0, 0, 1, 6, 0, 0, 0, "R7");
      // R11 idle cycles produce nothing
      cyc(0, 1, 0, 4, 0, 0, 0, 0, "R11");
      cyc(0, 0, 1, 1, 0, 0, 0, 0, "R11");
      // R9 saturation
      for (int i = 0; i < 260; i++) cyc(1, 0, 0, 12, 1, 0, 0, 0, "R9");
      cyc(1, 1, 0, 0, 0, 0, 0, 0, "R9");
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule